// File: doc/BRIEF.md
# Packet Character-Frequency Anomaly Flagger

This block watches a byte-wide packet stream and decides, once per packet, whether any single character value appeared more often than its permitted share of the packet length. Each character value has its own limit, expressed as a power-of-two fraction `2^-k` of the packet length. The per-character exponent `k` is written through a small configuration port. When the last byte of a packet has been accepted, a one-bit verdict appears together with a one-cycle valid strobe.

Internally there is one count entry per character value. Each entry holds a count and a generation tag. The generation advances at every start of packet, so the counts are never cleared in bulk: an entry whose tag differs from the current generation reads as zero. During the packet the block tracks only the largest shifted count (`count << k`). At the end it compares that single maximum against the final length, so there is no second pass over the counts.

Because the generation counter wraps, a background sweep uses idle cycles to zero any entry whose tag equals the generation that comes next. A start-of-packet byte is held off by `in_ready` until that sweep has covered every entry.

Top module: `charfreq_flagger`

## Requirements
- R1: For each packet the block reports `flag` = 1 exactly when some character c with count n_c in the packet satisfies `n_c << k_c > L`, where L is the number of bytes in the packet and k_c is that character's exponent. Otherwise it reports 0.
- R2: After reset every exponent is 0, so no character can flag. A write with `cfg_we` high sets the exponent of character `cfg_char` to `cfg_shift`.
- R3: The comparison uses the length of the whole packet. A packet whose early bytes are dense in one character, but whose full length keeps that character within its limit, reports 0.
- R4: Consecutive accepted bytes of the same character each add one to its count, with no lost update.
- R5: Counts from earlier packets never contribute to a later packet's verdict.
- R6: After the 4-bit generation has wrapped (16 start-of-packet bytes later), entries written by the packet that used the same generation value read as zero.
- R7: `in_ready` is 1 whenever `in_sop` is 0. With `in_sop` = 1, `in_ready` is 0 until the sweep has visited all 256 entries since the previous start of packet. The sweep visits one entry per cycle with no accepted byte. Directly after reset `in_ready` is 1.
- R8: `flag_valid` is 1 for exactly one cycle: the cycle after the clock edge that accepts the end-of-packet byte. It is 0 after reset, and `flag` is 1 only while `flag_valid` is 1.
- R9: A byte is counted only when `in_valid` and `in_ready` are both 1 at a clock edge. Data and markers presented while `in_valid` is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Exponent write enable |
| cfg_char | input | 8 | Character whose exponent is written |
| cfg_shift | input | 4 | Exponent k (limit is L / 2^k) |
| in_valid | input | 1 | Byte present on `in_data` |
| in_ready | output | 1 | Byte can be accepted this cycle |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| in_data | input | 8 | Character value |
| flag_valid | output | 1 | Verdict strobe, one cycle per packet |
| flag | output | 1 | Over-frequency verdict |

## Verification
Any fault in the count entries, the forwarding path or the generation tags shows up at `flag` only at the end-of-packet verdict. A count that is too low hides a flag, and a stale count that comes back raises a false one. For this reason the stimulus places the tested character so that the verdict depends on one count step. A fault in the sweep stays hidden until the generation wraps 16 packets later, so one scenario deliberately revisits a reused generation value. A fault in the stall logic shows within one cycle as an early or missing `in_ready` for a start-of-packet byte.

// File: rtl/cff_pkg.sv
package cff_pkg;
   // Default geometry shared by the flagger and its helpers.
   localparam int unsigned DEF_CHAR_W  = 8;
   localparam int unsigned DEF_COUNT_W = 16;
   localparam int unsigned DEF_GEN_W   = 4;
   localparam int unsigned DEF_SHIFT_W = 4;

   // Width needed to hold a count shifted by the largest exponent.
   function automatic int unsigned scaled_width(int unsigned cw, int unsigned sw);
      return cw + (1 << sw) - 1;
   endfunction
endpackage

// File: rtl/cff_count_store.sv
module cff_count_store #(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];
   logic          collide;

   // A read of the entry being written this cycle sees the new word.
   assign collide = wr_en && (wr_addr == rd_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         rd_data <= '0;
      end else begin
         if (wr_en) mem[wr_addr] <= wr_data;
         if (rd_en) rd_data <= collide ? wr_data : mem[rd_addr];
      end
   end
endmodule

// File: rtl/cff_shift_table.sv
module cff_shift_table #(
   parameter int unsigned AW = 8,
   parameter int unsigned SW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [SW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [SW-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [SW-1:0] tbl [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
      end else if (we) begin
         tbl[waddr] <= wdata;
      end
   end

   assign rdata = tbl[raddr];
endmodule

// File: rtl/cff_scrubber.sv
module cff_scrubber #(
   parameter int unsigned AW = 8,
   parameter int unsigned GW = 4,
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy,
   input  logic          restart,
   input  logic [GW-1:0] gen_next,
   input  logic [GW-1:0] rd_tag,
   input  logic [CW-1:0] rd_cnt,
   output logic          rd_req,
   output logic [AW-1:0] rd_addr,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic          sweep_done
);
   localparam logic [AW:0] FULL = {1'b1, {AW{1'b0}}};

   logic [AW-1:0] ptr;
   logic [AW-1:0] chk_addr;
   logic          chk_v;
   logic [AW:0]   visited;

   assign sweep_done = (visited == FULL);
   assign rd_req     = !busy && !sweep_done;
   assign rd_addr    = ptr;
   assign wr_en      = chk_v && (rd_tag == gen_next) && (rd_cnt != '0);
   assign wr_addr    = chk_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr      <= '0;
         chk_addr <= '0;
         chk_v    <= 1'b0;
         visited  <= FULL;
      end else begin
         chk_v <= rd_req;
         if (rd_req) begin
            ptr      <= ptr + 1'b1;
            chk_addr <= ptr;
         end
         if (restart)                  visited <= '0;
         else if (chk_v && !sweep_done) visited <= visited + 1'b1;
      end
   end
endmodule

// File: rtl/charfreq_flagger.sv
module charfreq_flagger
   import cff_pkg::*;
#(
   parameter int unsigned CHAR_W   = DEF_CHAR_W,
   parameter int unsigned COUNT_W  = DEF_COUNT_W,
   parameter int unsigned GEN_W    = DEF_GEN_W,
   parameter int unsigned SHIFT_W  = DEF_SHIFT_W,
   parameter bit          SATURATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [CHAR_W-1:0]  cfg_char,
   input  logic [SHIFT_W-1:0] cfg_shift,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic               in_sop,
   input  logic               in_eop,
   input  logic [CHAR_W-1:0]  in_data,
   output logic               flag_valid,
   output logic               flag
);
   localparam int unsigned ENTRY_W  = GEN_W + COUNT_W;
   localparam int unsigned SCALED_W = scaled_width(COUNT_W, SHIFT_W);

   if (CHAR_W < 1 || CHAR_W > 12) begin : g_bad_char
      $error("CHAR_W out of range");
   end
   if (GEN_W < 2) begin : g_bad_gen
      $error("GEN_W must be at least 2");
   end
   if (COUNT_W < 2 || SHIFT_W < 1 || SHIFT_W > 5) begin : g_bad_cnt
      $error("COUNT_W or SHIFT_W out of range");
   end

   // Input acceptance and generation.
   logic               accept;
   logic               sweep_done;
   logic [GEN_W-1:0]   gen_r;
   logic [GEN_W-1:0]   gen_next;

   assign in_ready = sweep_done || !in_sop;
   assign accept   = in_valid && in_ready;
   assign gen_next = gen_r + 1'b1;

   // Stage 1 registers: the byte whose entry read returns this cycle.
   logic               s1_valid, s1_sop, s1_eop;
   logic [CHAR_W-1:0]  s1_char;
   logic [GEN_W-1:0]   s1_gen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_r    <= '0;
         s1_valid <= 1'b0;
         s1_sop   <= 1'b0;
         s1_eop   <= 1'b0;
         s1_char  <= '0;
         s1_gen   <= '0;
      end else begin
         s1_valid <= accept;
         if (accept) begin
            s1_sop  <= in_sop;
            s1_eop  <= in_eop;
            s1_char <= in_data;
            s1_gen  <= in_sop ? gen_next : gen_r;
            if (in_sop) gen_r <= gen_next;
         end
      end
   end

   // Count store shared by the datapath and the sweep.
   logic               scrub_rd;
   logic [CHAR_W-1:0]  scrub_rd_addr;
   logic               scrub_we;
   logic [CHAR_W-1:0]  scrub_wr_addr;
   logic               s1_we;
   logic [ENTRY_W-1:0] rd_word;
   logic [GEN_W-1:0]   rd_tag;
   logic [COUNT_W-1:0] rd_cnt;
   logic               st_rd_en, st_we;
   logic [CHAR_W-1:0]  st_rd_addr, st_wr_addr;
   logic [ENTRY_W-1:0] st_wr_data;
   logic [COUNT_W-1:0] cnt_old, cnt_new;

   assign rd_tag  = rd_word[ENTRY_W-1 -: GEN_W];
   assign rd_cnt  = rd_word[COUNT_W-1:0];
   assign s1_we   = s1_valid;

   assign st_rd_en   = accept || scrub_rd;
   assign st_rd_addr = accept ? in_data : scrub_rd_addr;
   assign st_we      = s1_we || scrub_we;
   assign st_wr_addr = s1_we ? s1_char : scrub_wr_addr;
   assign st_wr_data = s1_we ? {s1_gen, cnt_new} : {rd_tag, {COUNT_W{1'b0}}};

   cff_count_store #(.AW(CHAR_W), .DW(ENTRY_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (st_rd_en),
      .rd_addr (st_rd_addr),
      .rd_data (rd_word),
      .wr_en   (st_we),
      .wr_addr (st_wr_addr),
      .wr_data (st_wr_data)
   );

   cff_scrubber #(.AW(CHAR_W), .GW(GEN_W), .CW(COUNT_W)) u_scrub (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy       (accept),
      .restart    (accept && in_sop),
      .gen_next   (gen_next),
      .rd_tag     (rd_tag),
      .rd_cnt     (rd_cnt),
      .rd_req     (scrub_rd),
      .rd_addr    (scrub_rd_addr),
      .wr_en      (scrub_we),
      .wr_addr    (scrub_wr_addr),
      .sweep_done (sweep_done)
   );

   // Lazy clear: a tag from another generation reads as zero.
   assign cnt_old = (rd_tag == s1_gen) ? rd_cnt : '0;

   if (SATURATE) begin : g_sat
      assign cnt_new = (cnt_old == '1) ? cnt_old : cnt_old + 1'b1;
   end else begin : g_wrap
      assign cnt_new = cnt_old + 1'b1;
   end

   // Exponent lookup and running maximum of shifted counts.
   logic [SHIFT_W-1:0]  s1_shift;
   logic [SCALED_W-1:0] scaled, max_r, max_base, max_next;
   logic [COUNT_W-1:0]  len_r, len_base, len_next;

   cff_shift_table #(.AW(CHAR_W), .SW(SHIFT_W)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .waddr (cfg_char),
      .wdata (cfg_shift),
      .raddr (s1_char),
      .rdata (s1_shift)
   );

   assign scaled   = SCALED_W'(cnt_new) << s1_shift;
   assign max_base = s1_sop ? '0 : max_r;
   assign max_next = (scaled > max_base) ? scaled : max_base;
   assign len_base = s1_sop ? '0 : len_r;
   assign len_next = (len_base == '1) ? len_base : len_base + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         max_r <= '0;
         len_r <= '0;
      end else if (s1_valid) begin
         max_r <= max_next;
         len_r <= len_next;
      end
   end

   assign flag_valid = s1_valid && s1_eop;
   assign flag       = flag_valid && (max_next > SCALED_W'(len_next));
endmodule

// File: rtl/charfreq_flagger_chk.sv
module charfreq_flagger_chk (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic in_sop,
   input logic in_eop,
   input logic flag_valid,
   input logic flag,
   input logic s1_we,
   input logic scrub_we
);
   p_eop_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_eop) |=> flag_valid);

   p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flag_valid |=> !flag_valid);

   p_flag_qualified_r1: assert property (@(posedge clk) disable iff (!rst_n)
      flag |-> flag_valid);

   p_nonsop_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_sop |-> in_ready);

   p_one_writer_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(s1_we && scrub_we));
endmodule

bind charfreq_flagger charfreq_flagger_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .in_sop     (in_sop),
   .in_eop     (in_eop),
   .flag_valid (flag_valid),
   .flag       (flag),
   .s1_we      (s1_we),
   .scrub_we   (scrub_we)
);

// File: tb/charfreq_flagger_test.sv
`timescale 1ns/1ps
module charfreq_flagger_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       cfg_we;
   logic [7:0] cfg_char;
   logic [3:0] cfg_shift;
   logic       in_valid, in_sop, in_eop;
   logic [7:0] in_data;
   logic       in_ready, flag_valid, flag;

   always #2 clk = ~clk;

   charfreq_flagger uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_char(cfg_char),
      .cfg_shift(cfg_shift), .in_valid(in_valid), .in_ready(in_ready),
      .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
      .flag_valid(flag_valid), .flag(flag)
   );

   int checks = 0;
   int fails  = 0;

   typedef struct packed {
      logic [7:0] ch;
      logic [7:0] rep;
      logic [7:0] len;
      logic       exp;
   } vec_t;

   // Target character repeated rep times first, then filler up to len bytes.
   localparam vec_t VECS [9] = '{
      '{8'h25, 8'd4, 8'd12, 1'b1},
      '{8'h25, 8'd3, 8'd12, 1'b0},
      '{8'h7E, 8'd2, 8'd16, 1'b0},
      '{8'h7E, 8'd3, 8'd16, 1'b1},
      '{8'h25, 8'd1, 8'd1,  1'b1},
      '{8'h61, 8'd5, 8'd5,  1'b0},
      '{8'h00, 8'd1, 8'd40, 1'b1},
      '{8'h25, 8'd0, 8'd20, 1'b0},
      '{8'h25, 8'd2, 8'd10, 1'b0}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] filler(input int i);
      return 8'h61 + 8'(i % 16);
   endfunction

   task automatic put(input logic [7:0] d, input bit s, input bit e);
      in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
      #1;
      while (!in_ready) begin
         @(negedge clk); #1;
      end
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
   endtask

   task automatic send(input logic [7:0] c, input int r, input int n);
      for (int i = 0; i < n; i++)
         put((i < r) ? c : filler(i - r), i == 0, i == n - 1);
   endtask

   task automatic result(input string req, input bit exp);
      chk(flag_valid === 1'b1, "R8", int'(flag_valid), 1);
      chk(flag === exp, req, int'(flag), int'(exp));
      @(negedge clk);
      chk(flag_valid === 1'b0, "R8", int'(flag_valid), 0);
   endtask

   task automatic set_k(input logic [7:0] c, input logic [3:0] k);
      @(negedge clk);
      cfg_we = 1'b1; cfg_char = c; cfg_shift = k;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   function automatic string vtag(input int v);
      case (v)
         0: return "R4";
         1: return "R5";
         8: return "R3";
         default: return "R1";
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_char = '0; cfg_shift = '0;
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state (R8, R7).
      chk(flag_valid === 1'b0, "R8", int'(flag_valid), 0);
      in_sop = 1'b1; #1;
      chk(in_ready === 1'b1, "R7", int'(in_ready), 1);
      in_sop = 1'b0;

      // R2: default exponent 0 never flags (3 of 3 bytes).
      send(8'h25, 3, 3);
      result("R2", 1'b0);

      set_k(8'h25, 4'd2);
      set_k(8'h7E, 4'd3);
      set_k(8'h00, 4'd15);

      // Table of vectors.
      for (int v = 0; v < 9; v++) begin
         send(VECS[v].ch, int'(VECS[v].rep), int'(VECS[v].len));
         result(vtag(v), VECS[v].exp);
      end

      // R9: bytes with valid low are not counted (2 of 10, k=2 -> 8 > 10 false).
      put(8'h25, 1'b1, 1'b0);
      put(8'h25, 1'b0, 1'b0);
      in_data = 8'h25; in_eop = 1'b1;
      repeat (5) @(negedge clk);
      in_eop = 1'b0;
      for (int i = 0; i < 8; i++) put(filler(i), 1'b0, i == 7);
      result("R9", 1'b0);

      // R6: heavy packet, 15 other packets, then same generation reused.
      send(8'h7E, 8, 8);
      result("R6", 1'b1);
      for (int p = 0; p < 15; p++) begin
         send(8'h62, 1, 1);
         result("R6", 1'b0);
      end
      send(8'h7E, 1, 16);
      result("R6", 1'b0);

      // R7: start of packet held off until the sweep completes.
      begin
         int waited;
         waited = 0;
         in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_data = 8'h61;
         #1;
         chk(in_ready === 1'b0, "R7", int'(in_ready), 0);
         while (!in_ready && waited < 400) begin
            @(negedge clk); #1;
            waited++;
         end
         chk(waited >= 250 && waited <= 270, "R7", waited, 257);
         @(negedge clk);
         in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
         result("R7", 1'b0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule